// File: doc/BRIEF.md
# Four-Digit Alphanumeric Display Controller

This block is the host-side logic of a four-character alphanumeric display. A host writes through a small parallel bus with two chip enables, separate read and write strobes, a 3-bit address and an 8-bit data path. Each write goes to one of four character entries or to a single control word. A character entry holds a 7-bit ASCII code plus one attribute flag. The control word sets brightness and picks how flagged digits behave: steady, blinking to blank, or alternating with a cursor that lights every dot. One control bit blinks the whole display whatever the flags say.

For each digit the block drives the ASCII code to render and a display mode. The font lookup and dot scanning that follow are outside this block. The block also drives a brightness gate that a PWM counter produces, and it holds a blink timebase that sets the on and off phases.

Two small state machines control the block. The bus sequencer has three states. BUS_IDLE goes to BUS_WRITE when a write request appears, and that edge commits the data. BUS_IDLE goes to BUS_READ when a read request appears. BUS_WRITE returns to BUS_IDLE when the write request ends, and BUS_READ returns to BUS_IDLE when the read request ends. The blink timebase has two states. PHASE_ON and PHASE_OFF hand over to each other every time the prescaler finishes one half period. The timebase enters PHASE_ON at reset.

Top module: `quad_char_display`

## Requirements
- R1: A write is taken only when ce0_n=0, ce1=1, rd_n=1 and wr_n=0. Any other combination of strobes, including both strobes low, leaves every stored value unchanged. Each write strobe commits once, on the first clock edge at which it is seen.
- R2: addr[2]=1 selects a character entry and addr[2]=0 selects the control word. When the control word is selected, addr[1:0] are ignored. For characters, addr[1:0]=3 is the leftmost digit (index 3) and 0 is the rightmost digit (index 0).
- R3: A character write stores wdata[6:0] as the code and wdata[7] as the attribute flag. Digit i shows its code on digit_code[7*i+6:7*i].
- R4: After reset every code is ASCII space (0x20), every flag is clear, the control word is 0x00, every digit is in mode 0, and rdata_oe is low.
- R5: Control bits [1:0] give the brightness level L. Over each period of the free-running PWM counter (16 cycles by default), bright_gate is high for 4*(L+1) cycles, and for L=3 it is high in every cycle.
- R6: digit_mode[2*i+1:2*i] reports 0 for character, 1 for blank and 2 for cursor. When control bit 4 is set, a flagged digit is blank in the off phase and shows its character in the on phase. Unflagged digits stay in mode 0.
- R7: When control bits 4 and 3 are both set, a flagged digit shows the cursor (mode 2) in the off phase, where R6 would blank it.
- R8: When control bit 5 is set, all four digits are blank in the off phase whatever their flags. This takes priority over R6 and R7. In the on phase every digit shows its character.
- R9: Control bits 2, 6 and 7 are stored and read back but have no effect on any digit output.
- R10: When ce0_n=0, ce1=1, rd_n=0 and wr_n=1, the clock edge that samples these strobes loads rdata with the addressed entry (flag in bit 7, code in bits 6:0), or with the control word, and raises rdata_oe. In any other cycle, rdata is 0x00 and rdata_oe is low.
- R11: The blink phase starts in the on state at reset and flips after every CLK_HZ/(2*BLINK_HZ) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Bit 2 selects the character entries; bits 1:0 pick the digit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rdata_oe | output | 1 | Read data valid / drive enable |
| digit_code | output | 28 | ASCII code per digit, 7 bits each, digit 0 in the low bits |
| digit_mode | output | 8 | Mode per digit, 2 bits each: 0 character, 1 blank, 2 cursor |
| bright_gate | output | 1 | Brightness PWM gate |

## Verification
The bench replays a full load sequence: brightness, four letters, a flagged letter, then the control modes. After each step it checks the digit modes in both blink phases. A design that ignores the flag blinks every digit. A design that swaps blank and cursor fails the alternate step. A design with the wrong priority lets flagged digits become cursors while the whole display should be dark. Further tests target writes with wrong strobe combinations, which a loose decode would accept. They also test the low address bits on a control write, which a full decode would drop, and the inert control bits, which could disturb the modes. Brightness is checked by counting gate cycles at each level. The first phase change after reset is checked at its exact cycle, so an off-by-one prescaler or a phase that starts off shows up.

// File: rtl/qcd_pkg.sv
package qcd_pkg;

    localparam int CODE_W    = 7;
    localparam int ENTRY_W   = 8;
    localparam int MODE_W    = 2;
    localparam int CW_ALT    = 3;
    localparam int CW_BLINK  = 4;
    localparam int CW_ALL    = 5;
    localparam logic [ENTRY_W-1:0] ENTRY_RESET = 8'h20;

    typedef enum logic [MODE_W-1:0] {
        DM_CHAR   = 2'd0,
        DM_BLANK  = 2'd1,
        DM_CURSOR = 2'd2
    } disp_mode_e;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_WRITE = 2'd1,
        BUS_READ  = 2'd2
    } bus_state_e;

    typedef enum logic {
        PHASE_ON  = 1'b0,
        PHASE_OFF = 1'b1
    } blink_state_e;

endpackage

// File: rtl/qcd_bus_regs.sv
module qcd_bus_regs
    import qcd_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int DIG_W      = $clog2(NUM_DIGITS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ce0_n,
    input  logic                          ce1,
    input  logic                          rd_n,
    input  logic                          wr_n,
    input  logic [DIG_W:0]                addr,
    input  logic [ENTRY_W-1:0]            wdata,
    output logic [ENTRY_W-1:0]            rdata,
    output logic                          rdata_oe,
    output logic [NUM_DIGITS*ENTRY_W-1:0] chars_flat,
    output logic [ENTRY_W-1:0]            ctrl_word
);

    bus_state_e         state_q, state_d;
    logic               selected, wr_req, rd_req, commit;
    logic               sel_chars;
    logic [DIG_W-1:0]   idx;
    logic [ENTRY_W-1:0] chars_q [NUM_DIGITS];
    logic [ENTRY_W-1:0] ctrl_q;
    logic [ENTRY_W-1:0] read_mux;

    assign selected  = !ce0_n && ce1;
    assign wr_req    = selected && rd_n && !wr_n;
    assign rd_req    = selected && !rd_n && wr_n;
    assign sel_chars = addr[DIG_W];
    assign idx       = addr[DIG_W-1:0];

    // Next-state logic of the bus sequencer
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (wr_req)      state_d = BUS_WRITE;
                else if (rd_req) state_d = BUS_READ;
            end
            BUS_WRITE: if (!wr_req) state_d = BUS_IDLE;
            BUS_READ:  if (!rd_req) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // A write strobe commits only on its first sampled edge
    assign commit = (state_q == BUS_IDLE) && wr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_DIGITS; i++) chars_q[i] <= ENTRY_RESET;
            ctrl_q <= '0;
        end else if (commit) begin
            if (sel_chars) chars_q[idx] <= wdata;
            else           ctrl_q       <= wdata;
        end
    end

    assign read_mux = sel_chars ? chars_q[idx] : ctrl_q;

    // Output process: registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata    <= '0;
            rdata_oe <= 1'b0;
        end else begin
            rdata    <= rd_req ? read_mux : '0;
            rdata_oe <= rd_req;
        end
    end

    always_comb begin
        for (int i = 0; i < NUM_DIGITS; i++) chars_flat[i*ENTRY_W +: ENTRY_W] = chars_q[i];
    end

    assign ctrl_word = ctrl_q;

endmodule

// File: rtl/qcd_blink_timer.sv
module qcd_blink_timer
    import qcd_pkg::*;
#(
    parameter int HALF_PERIOD = 8,
    parameter int CNT_W       = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic blink_on
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_PERIOD - 1);

    blink_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PHASE_ON:  if (tick) state_d = PHASE_OFF;
            PHASE_OFF: if (tick) state_d = PHASE_ON;
            default:   state_d = PHASE_ON;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PHASE_ON;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    // Output process
    always_comb begin
        blink_on = (state_q == PHASE_ON);
    end

endmodule

// File: rtl/qcd_dim_pwm.sv
module qcd_dim_pwm #(
    parameter int PWM_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] level,
    output logic       gate
);

    logic [PWM_W-1:0] cnt_q;
    logic [1:0]       slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Top two counter bits split the period into four equal slots
    assign slot = cnt_q[PWM_W-1 -: 2];
    assign gate = (level == 2'b11) || (slot <= level);

endmodule

// File: rtl/qcd_digit_mux.sv
module qcd_digit_mux
    import qcd_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic [NUM_DIGITS*ENTRY_W-1:0] chars_flat,
    input  logic                          blink_en,
    input  logic                          alt_en,
    input  logic                          all_blink,
    input  logic                          blink_on,
    output logic [NUM_DIGITS*CODE_W-1:0]  digit_code,
    output logic [NUM_DIGITS*MODE_W-1:0]  digit_mode
);

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
        logic [ENTRY_W-1:0] ent;
        disp_mode_e         mode;

        assign ent = chars_flat[g*ENTRY_W +: ENTRY_W];

        always_comb begin
            if (all_blink && !blink_on)
                mode = DM_BLANK;
            else if (blink_en && ent[ENTRY_W-1] && !blink_on)
                mode = alt_en ? DM_CURSOR : DM_BLANK;
            else
                mode = DM_CHAR;
        end

        assign digit_code[g*CODE_W +: CODE_W] = ent[CODE_W-1:0];
        assign digit_mode[g*MODE_W +: MODE_W] = mode;
    end

endmodule

// File: rtl/quad_char_display.sv
module quad_char_display
    import qcd_pkg::*;
#(
    parameter int NUM_DIGITS = 4,
    parameter int DIG_W      = $clog2(NUM_DIGITS),
    parameter int CLK_HZ     = 50_000_000,
    parameter int BLINK_HZ   = 2,
    parameter int PWM_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce0_n,
    input  logic                         ce1,
    input  logic                         rd_n,
    input  logic                         wr_n,
    input  logic [DIG_W:0]               addr,
    input  logic [7:0]                   wdata,
    output logic [7:0]                   rdata,
    output logic                         rdata_oe,
    output logic [NUM_DIGITS*7-1:0]      digit_code,
    output logic [NUM_DIGITS*2-1:0]      digit_mode,
    output logic                         bright_gate
);

    localparam int BLINK_HALF = CLK_HZ / (2 * BLINK_HZ);

    logic [NUM_DIGITS*ENTRY_W-1:0] chars_flat;
    logic [ENTRY_W-1:0]            ctrl_word;
    logic                          blink_on;

    qcd_bus_regs #(
        .NUM_DIGITS (NUM_DIGITS),
        .DIG_W      (DIG_W)
    ) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce0_n      (ce0_n),
        .ce1        (ce1),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .rdata_oe   (rdata_oe),
        .chars_flat (chars_flat),
        .ctrl_word  (ctrl_word)
    );

    qcd_blink_timer #(
        .HALF_PERIOD (BLINK_HALF)
    ) i_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .blink_on (blink_on)
    );

    qcd_dim_pwm #(
        .PWM_W (PWM_W)
    ) i_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctrl_word[1:0]),
        .gate  (bright_gate)
    );

    qcd_digit_mux #(
        .NUM_DIGITS (NUM_DIGITS)
    ) i_mux (
        .chars_flat (chars_flat),
        .blink_en   (ctrl_word[CW_BLINK]),
        .alt_en     (ctrl_word[CW_ALT]),
        .all_blink  (ctrl_word[CW_ALL]),
        .blink_on   (blink_on),
        .digit_code (digit_code),
        .digit_mode (digit_mode)
    );

endmodule

// File: rtl/qcd_checker.sv
module qcd_checker #(
    parameter int NUM_DIGITS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ce0_n,
    input logic                    ce1,
    input logic                    rd_n,
    input logic                    wr_n,
    input logic [7:0]              ctrl_word,
    input logic                    blink_on,
    input logic [NUM_DIGITS*2-1:0] digit_mode,
    input logic                    bright_gate,
    input logic [7:0]              rdata,
    input logic                    rdata_oe
);

    logic wr_req, rd_req, all_blank, any_cursor, any_bad;

    assign wr_req = !ce0_n && ce1 && rd_n && !wr_n;
    assign rd_req = !ce0_n && ce1 && !rd_n && wr_n;

    always_comb begin
        all_blank  = 1'b1;
        any_cursor = 1'b0;
        any_bad    = 1'b0;
        for (int i = 0; i < NUM_DIGITS; i++) begin
            if (digit_mode[i*2 +: 2] != 2'd1) all_blank  = 1'b0;
            if (digit_mode[i*2 +: 2] == 2'd2) any_cursor = 1'b1;
            if (digit_mode[i*2 +: 2] == 2'd3) any_bad    = 1'b1;
        end
    end

    a_r1_ctrl_held: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(ctrl_word));

    a_r10_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rdata_oe);

    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rdata_oe && rdata == 8'h00));

    a_r5_full_bright: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[1:0] == 2'b11) |-> bright_gate);

    a_r6_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !any_bad);

    a_r7_cursor_source: assert property (@(posedge clk) disable iff (!rst_n)
        any_cursor |-> (ctrl_word[4] && ctrl_word[3] && !blink_on));

    a_r8_full_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[5] && !blink_on) |-> all_blank);

endmodule

bind quad_char_display qcd_checker #(
    .NUM_DIGITS (NUM_DIGITS)
) i_qcd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce0_n       (ce0_n),
    .ce1         (ce1),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .ctrl_word   (ctrl_word),
    .blink_on    (blink_on),
    .digit_mode  (digit_mode),
    .bright_gate (bright_gate),
    .rdata       (rdata),
    .rdata_oe    (rdata_oe)
);

// File: tb/test_quad_char_display.sv
module test_quad_char_display;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 32;
    localparam int BLINK_HZ   = 2;
    localparam int HALF       = CLK_HZ / (2 * BLINK_HZ);
    localparam int PWM_PERIOD = 16;

    typedef struct packed {
        logic [2:0]  a;
        logic [7:0]  d;
        logic [27:0] codes;
        logic [7:0]  m_on;
        logic [7:0]  m_off;
    } vec_t;

    localparam logic [27:0] SPC4 = {7'h20, 7'h20, 7'h20, 7'h20};
    localparam logic [27:0] STOP = {7'h53, 7'h54, 7'h4F, 7'h50};

    localparam vec_t VEC [10] = '{
        '{3'b000, 8'h03, SPC4,                            8'h00, 8'h00},
        '{3'b111, 8'h53, {7'h53, 7'h20, 7'h20, 7'h20},    8'h00, 8'h00},
        '{3'b110, 8'h54, {7'h53, 7'h54, 7'h20, 7'h20},    8'h00, 8'h00},
        '{3'b101, 8'h4F, {7'h53, 7'h54, 7'h4F, 7'h20},    8'h00, 8'h00},
        '{3'b100, 8'h50, STOP,                            8'h00, 8'h00},
        '{3'b101, 8'hCF, STOP,                            8'h00, 8'h00},
        '{3'b000, 8'h17, STOP,                            8'h00, 8'h04},
        '{3'b111, 8'hD3, STOP,                            8'h00, 8'h44},
        '{3'b000, 8'h1F, STOP,                            8'h00, 8'h88},
        '{3'b000, 8'h23, STOP,                            8'h00, 8'h55}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce0_n = 1'b1, ce1 = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic [27:0] digit_code;
    logic [7:0]  digit_mode;
    logic        bright_gate;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    quad_char_display #(
        .CLK_HZ   (CLK_HZ),
        .BLINK_HZ (BLINK_HZ)
    ) i_quad_char_display (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce0_n       (ce0_n),
        .ce1         (ce1),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .rdata_oe    (rdata_oe),
        .digit_code  (digit_code),
        .digit_mode  (digit_mode),
        .bright_gate (bright_gate)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        ce0_n = 1'b1; ce1 = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_cycle(input logic c0n, input logic c1, input logic rdn,
                             input logic wrn, input logic [2:0] a, input logic [7:0] d);
        ce0_n = c0n; ce1 = c1; rd_n = rdn; wr_n = wrn; addr = a; wdata = d;
        @(posedge clk); #1;
        go_idle();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_cycle(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    endtask

    task automatic bus_read(input string req, input logic [2:0] a, input logic [7:0] exp);
        ce0_n = 1'b0; ce1 = 1'b1; rd_n = 1'b0; wr_n = 1'b1; addr = a;
        @(posedge clk); #1;
        chk(req, {24'h0, rdata}, {24'h0, exp});
        chk("R10 oe during read", {31'h0, rdata_oe}, 32'h1);
        go_idle();
        @(posedge clk); #1;
        chk("R10 oe after read", {23'h0, rdata_oe, rdata}, 32'h0);
    endtask

    function automatic bit phase_on();
        return ((cyc / HALF) % 2) == 0;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        go_idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic chk_both_phases(input string req, input logic [7:0] m_on, input logic [7:0] m_off);
        chk(req, {24'h0, digit_mode}, {24'h0, phase_on() ? m_on : m_off});
        repeat (HALF) @(posedge clk);
        #1;
        chk(req, {24'h0, digit_mode}, {24'h0, phase_on() ? m_on : m_off});
    endtask

    initial begin
        do_reset();

        // R4: reset state
        chk("R4 codes", {4'h0, digit_code}, {4'h0, SPC4});
        chk("R4 modes", {24'h0, digit_mode}, 32'h0);
        chk("R4 oe", {31'h0, rdata_oe}, 32'h0);
        bus_read("R4 control word", 3'b000, 8'h00);
        bus_read("R4 flag clear", 3'b110, 8'h20);

        // Vector table: load sequence (R3, R6, R7, R8)
        for (int v = 0; v < 10; v++) begin
            bus_write(VEC[v].a, VEC[v].d);
            chk("R3 codes", {4'h0, digit_code}, {4'h0, VEC[v].codes});
            chk_both_phases("R6 blink mode", VEC[v].m_on, VEC[v].m_off);
        end

        // R10 and R2: read back entries and control word through decoded addresses
        bus_read("R10 ctrl", 3'b001, 8'h23);
        bus_read("R2 leftmost", 3'b111, 8'hD3);
        bus_read("R10 flagged O", 3'b101, 8'hCF);
        bus_read("R2 rightmost", 3'b100, 8'h50);

        // R1: rejected strobe combinations
        bus_cycle(1'b0, 1'b0, 1'b1, 1'b0, 3'b000, 8'h00);
        bus_cycle(1'b1, 1'b1, 1'b1, 1'b0, 3'b100, 8'h41);
        bus_cycle(1'b0, 1'b1, 1'b0, 1'b0, 3'b100, 8'h42);
        bus_read("R1 ctrl unchanged", 3'b000, 8'h23);
        chk("R1 codes unchanged", {4'h0, digit_code}, {4'h0, STOP});

        // R1: a long strobe with changing data commits only the first value
        ce0_n = 1'b0; ce1 = 1'b1; rd_n = 1'b1; wr_n = 1'b0; addr = 3'b100; wdata = 8'h58;
        @(posedge clk); #1;
        wdata = 8'h59;
        @(posedge clk); #1;
        go_idle();
        @(posedge clk); #1;
        chk("R1 single commit", {25'h0, digit_code[6:0]}, 32'h58);
        bus_write(3'b100, 8'h50);

        // R2 + R8: control write through addr 010, priority of full blink
        bus_write(3'b010, 8'h3B);
        chk_both_phases("R8 priority", 8'h00, 8'h55);
        bus_read("R2 ctrl alias", 3'b011, 8'h3B);

        // R7: alternate mode, unflagged digits unaffected
        bus_write(3'b000, 8'h1B);
        chk_both_phases("R7 cursor", 8'h00, 8'h88);

        // R9: inert control bits
        bus_write(3'b000, 8'hC7);
        chk_both_phases("R9 inert bits", 8'h00, 8'h00);
        bus_read("R9 readback", 3'b000, 8'hC7);

        // R5: brightness duty per level
        for (int lvl = 0; lvl < 4; lvl++) begin
            int hi;
            hi = 0;
            bus_write(3'b000, 8'(lvl));
            for (int k = 0; k < PWM_PERIOD; k++) begin
                @(posedge clk); #1;
                if (bright_gate) hi++;
            end
            chk("R5 duty", hi, 4 * (lvl + 1));
        end

        // R11: exact first phase change after reset
        do_reset();
        bus_write(3'b000, 8'h23);
        while (cyc != HALF - 1) @(negedge clk);
        chk("R11 still on", {24'h0, digit_mode}, 32'h00);
        while (cyc != HALF) @(negedge clk);
        chk("R11 first off", {24'h0, digit_mode}, 32'h55);
        while (cyc != 2 * HALF) @(negedge clk);
        chk("R11 back on", {24'h0, digit_mode}, 32'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule